// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a host-side master that fetches a single value from a three-wire serial EEPROM. A request carries an address and a flag that picks word (16-bit) or byte (8-bit) organisation. The block frames the transfer with a chip select, drives the serial clock and the serial output line, and samples the device's serial output. It first sends a start bit and the read opcode, then the address MSB first. It then clocks in the data bits and presents them on `rdData` with a one-cycle `done` pulse.

Some boards leave the device's leading zero bit in the data stream instead of swallowing it during the last address clock. For those boards, the `extraCycle` input adds one clock pulse between the address and the first captured bit, so that the zero is thrown away. The serial clock is derived from the system clock through a programmable half-period divider. `busy` covers the whole transaction, including a closing gap with chip select low.

Top module: `uwire_rom_reader`

## Requirements
- R1: Every transfer begins with the bits 1, 1, 0 on `serOut`, followed by the address MSB first. `serOut` changes only while `serClk` is low, and `serIn` is sampled on the rising edge of `serClk`.
- R2: With `reqByteMode`=0 the address is `reqAddr[5:0]`, giving a 9-bit command. Sixteen bits are then captured, first bit into `rdData[15]`.
- R3: With `reqByteMode`=1 the address is `reqAddr[6:0]`, giving a 10-bit command. Eight bits are captured into `rdData[7:0]`, first bit into `rdData[7]`, and `rdData[15:8]` reads 0.
- R4: With `extraCycle`=1 one additional clock pulse is issued after the last address bit, and nothing is sampled during it. The transfer then has command+1+data rising edges instead of command+data. On a device that emits a leading 0 this yields the correct value; on one that does not, the value comes out shifted left by one.
- R5: Each half of a serial clock period lasts `clkDiv`+1 system clocks. `done` goes high exactly 2·(`clkDiv`+1)·(rising edge count) cycles after the clock edge that accepts the request.
- R6: `serCs` is high from acceptance until the falling edge after the last data bit, and `serClk` is low whenever `serCs` is low. `busy` stays high for 2·(`clkDiv`+1) cycles after `done` with `serCs` low, then drops.
- R7: A request is accepted only while `busy` is 0. `reqValid` pulses during a transfer leave its clock count and its result unchanged and start no new transfer.
- R8: `done` is high for exactly one cycle per transfer. `rdData` holds its value until the next `done`.
- R9: During reset `busy`, `done`, `serCs`, `serClk` and `serOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a read when not busy |
| reqAddr | input | 7 | Address; bit 6 used in byte mode only |
| reqByteMode | input | 1 | 1 = byte organisation, 0 = word |
| extraCycle | input | 1 | Insert one clock pulse before capture |
| clkDiv | input | 8 | Serial half-period minus one, in system clocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse, `rdData` valid |
| rdData | output | 16 | Captured value |
| serCs | output | 1 | Chip select to the EEPROM |
| serClk | output | 1 | Serial clock to the EEPROM |
| serOut | output | 1 | Serial command data to the EEPROM |
| serIn | input | 1 | Serial data from the EEPROM |

## Verification
All results can be predicted from the half-period H = `clkDiv`+1 and the rising-edge count N. `done` is due exactly 2·H·N cycles after the accepting edge, and `busy` falls 2·H cycles after `done`. The bench drives inputs on falling system-clock edges and counts falling edges from the request. It expects `done` at count 2·H·N+1 and `busy` low at a count 2·H later, so every sample is taken half a cycle after the register that produces it has updated. A behavioural device model shifts data out on falling serial edges, with or without a leading zero, and checks the received command bits against the request.

// File: rtl/uwire_rd_pkg.sv
package uwire_rd_pkg;

  // start bit followed by the two-bit read opcode
  localparam logic [2:0] READ_PREFIX = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP,
    ST_DATA,
    ST_TAIL
  } rdState_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic shiftCmd;
    logic sampleIn;
    logic publish;
  } pathCtl_t;

endpackage

// File: rtl/uwire_rd_tick.sv
module uwire_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run || cnt == clkDiv) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == clkDiv);

endmodule

// File: rtl/uwire_rd_ctrl.sv
module uwire_rd_ctrl
  import uwire_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqByteMode,
  input  logic     extraCycle,
  input  logic     tick,
  output logic     busy,
  output logic     serCs,
  output logic     done,
  output pathCtl_t ctl
);

  localparam int CMD_WORD  = 3 + ADDR_W;
  localparam int CMD_BYTE  = CMD_WORD + 1;
  localparam int DATA_BYTE = DATA_W / 2;
  localparam int CNT_W     = $clog2(CMD_BYTE + DATA_W + 1);

  rdState_t         state;
  logic             phaseHigh;
  logic [CNT_W-1:0] bitCnt;
  logic             byteSel;
  logic             extraSel;
  logic [CNT_W-1:0] dataLast;

  assign busy     = (state != ST_IDLE);
  assign dataLast = byteSel ? CNT_W'(DATA_BYTE - 1) : CNT_W'(DATA_W - 1);

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && reqValid;
    ctl.rise     = tick && !phaseHigh && (state != ST_TAIL);
    ctl.fall     = tick && phaseHigh;
    ctl.shiftCmd = ctl.fall && (state == ST_CMD);
    ctl.sampleIn = ctl.rise && (state == ST_DATA);
    ctl.publish  = ctl.fall && (state == ST_DATA) && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseHigh <= 1'b0;
      bitCnt    <= '0;
      byteSel   <= 1'b0;
      extraSel  <= 1'b0;
      serCs     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state     <= ST_CMD;
            byteSel   <= reqByteMode;
            extraSel  <= extraCycle;
            bitCnt    <= reqByteMode ? CNT_W'(CMD_BYTE - 1) : CNT_W'(CMD_WORD - 1);
            phaseHigh <= 1'b0;
            serCs     <= 1'b1;
          end
        end
        ST_CMD, ST_GAP, ST_DATA: begin
          if (tick) begin
            if (!phaseHigh) begin
              phaseHigh <= 1'b1;
            end else begin
              phaseHigh <= 1'b0;
              if (bitCnt != '0) begin
                bitCnt <= bitCnt - 1'b1;
              end else if (state == ST_CMD) begin
                if (extraSel) begin
                  state  <= ST_GAP;
                  bitCnt <= '0;
                end else begin
                  state  <= ST_DATA;
                  bitCnt <= dataLast;
                end
              end else if (state == ST_GAP) begin
                state  <= ST_DATA;
                bitCnt <= dataLast;
              end else begin
                state  <= ST_TAIL;
                bitCnt <= CNT_W'(1);
                serCs  <= 1'b0;
                done   <= 1'b1;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (bitCnt != '0) bitCnt <= bitCnt - 1'b1;
            else              state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uwire_rd_path.sv
module uwire_rd_path
  import uwire_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByteMode,
  input  logic              serIn,
  output logic              serClk,
  output logic              serOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int CMD_W = ADDR_W + 4;

  logic [CMD_W-1:0]  cmdSh;
  logic [DATA_W-1:0] dataSh;
  logic [CMD_W-1:0]  cmdWord;
  logic [CMD_W-1:0]  cmdByte;

  // word command is left aligned, padded with a trailing zero
  assign cmdWord = {READ_PREFIX, reqAddr[ADDR_W-1:0], 1'b0};
  assign cmdByte = {READ_PREFIX, reqAddr};
  assign serOut  = cmdSh[CMD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSh  <= '0;
      dataSh <= '0;
      rdData <= '0;
      serClk <= 1'b0;
    end else begin
      if (ctl.load) begin
        cmdSh  <= reqByteMode ? cmdByte : cmdWord;
        dataSh <= '0;
      end else begin
        if (ctl.shiftCmd) cmdSh  <= {cmdSh[CMD_W-2:0], 1'b0};
        if (ctl.sampleIn) dataSh <= {dataSh[DATA_W-2:0], serIn};
      end
      if (ctl.rise)         serClk <= 1'b1;
      else if (ctl.fall)    serClk <= 1'b0;
      if (ctl.publish)      rdData <= dataSh;
    end
  end

endmodule

// File: rtl/uwire_rom_reader.sv
module uwire_rom_reader
  import uwire_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByteMode,
  input  logic              extraCycle,
  input  logic [DIV_W-1:0]  clkDiv,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              serCs,
  output logic              serClk,
  output logic              serOut,
  input  logic              serIn
);

  pathCtl_t ctl;
  logic     tick;

  uwire_rd_tick #(.DIV_W(DIV_W)) tickGen (
    .clk    (clk),
    .rstN   (rstN),
    .run    (busy),
    .clkDiv (clkDiv),
    .tick   (tick)
  );

  uwire_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqByteMode (reqByteMode),
    .extraCycle  (extraCycle),
    .tick        (tick),
    .busy        (busy),
    .serCs       (serCs),
    .done        (done),
    .ctl         (ctl)
  );

  uwire_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) shifter (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqAddr     (reqAddr),
    .reqByteMode (reqByteMode),
    .serIn       (serIn),
    .serClk      (serClk),
    .serOut      (serOut),
    .rdData      (rdData)
  );

endmodule

// File: rtl/uwire_rd_checker.sv
module uwire_rd_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqByteMode,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic              serCs,
  input logic              serClk,
  input logic              serOut
);

  logic lastByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lastByte <= 1'b0;
    else if (reqValid && !busy) lastByte <= reqByteMode;
  end

  // R1: command line held steady while the serial clock is high
  a_r1_out_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serOut));

  // R6: no clock pulse outside a chip-select frame
  a_r6_clk_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> serCs);

  // R6: frame already closed when the result is announced
  a_r6_frame_closed_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !serCs);

  // R7: busy covers every selected frame
  a_r7_busy_covers_frame: assert property (@(posedge clk) disable iff (!rstN)
    serCs |-> busy);

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: byte reads leave the upper half clear
  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastByte) |-> (rdData[DATA_W-1:DATA_W/2] == '0));

endmodule

bind uwire_rom_reader uwire_rd_checker #(.DATA_W(DATA_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqByteMode (reqByteMode),
  .busy        (busy),
  .done        (done),
  .rdData      (rdData),
  .serCs       (serCs),
  .serClk      (serClk),
  .serOut      (serOut)
);

// File: tb/uwire_rom_reader_test.sv
`timescale 1ns/1ps
module uwire_rom_reader_test;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [ADDR_W:0]   reqAddr;
  logic              reqByteMode;
  logic              extraCycle;
  logic [DIV_W-1:0]  clkDiv;
  logic              busy, done, serCs, serClk, serOut, serIn;
  logic [DATA_W-1:0] rdData;

  always #2.5 clk = ~clk;

  uwire_rom_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqByteMode(reqByteMode), .extraCycle(extraCycle), .clkDiv(clkDiv),
    .busy(busy), .done(done), .rdData(rdData), .serCs(serCs),
    .serClk(serClk), .serOut(serOut), .serIn(serIn)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int               rises   = 0;
  int               cmdLenM = 9;
  int               dLenM   = 16;
  bit               lagM    = 1'b0;
  logic [15:0]      devWord = '0;
  int               rxBits  = 0;
  int               csViol  = 0;
  logic             devOut  = 1'b0;

  assign serIn = devOut & serCs;

  always @(posedge serClk) begin
    rises++;
    if (rises <= cmdLenM) rxBits = (rxBits << 1) | int'(serOut);
    if (!serCs) csViol++;
  end

  always @(negedge serClk) begin
    if (serCs && rises >= cmdLenM) begin
      int k;
      int idx;
      k   = rises - cmdLenM;
      idx = lagM ? k - 1 : k;
      devOut = (idx >= 0 && idx < dLenM) ? devWord[dLenM-1-idx] : 1'b0;
    end
  end

  // ---------------- reference functions ----------------
  function automatic logic [15:0] wordAt(input int a);
    return 16'((a * 40503 + 16'h1D3B) ^ (a << 9));
  endfunction

  function automatic logic [15:0] byteAt(input int b);
    return {8'h00, 8'((b * 167 + 8'h5C) ^ (b >> 3))};
  endfunction

  function automatic logic [15:0] expData(input logic [15:0] w, input int dLen,
                                          input bit extra, input bit lag);
    logic [15:0] mask;
    mask = (dLen == 16) ? 16'hFFFF : 16'h00FF;
    if (extra == lag) return w & mask;
    if (extra)        return (w << 1) & mask;
    return (w & mask) >> 1;
  endfunction

  // ---------------- one transaction ----------------
  task automatic readOnce(input int addr, input bit byteM, input bit extra,
                          input bit lag, input int div, input bit poke);
    int half, nBits, lat, k, doneK, lowK, doneCnt, expCmd, limit;
    logic [15:0] got, exp;
    bit finished;
    string rq;
    rq      = byteM ? "R3" : "R2";
    cmdLenM = 3 + ADDR_W + int'(byteM);
    dLenM   = byteM ? 8 : 16;
    lagM    = lag;
    devWord = byteM ? byteAt(addr) : wordAt(addr);
    rises   = 0;
    rxBits  = 0;
    csViol  = 0;
    half    = div + 1;
    nBits   = cmdLenM + int'(extra) + dLenM;
    lat     = 2 * half * nBits;
    limit   = lat + 4 * half + 40;
    exp     = expData(devWord, dLenM, extra, lag);
    expCmd  = (6 << (ADDR_W + int'(byteM))) | (addr & ((1 << (ADDR_W + int'(byteM))) - 1));

    @(negedge clk);
    reqValid    = 1'b1;
    reqAddr     = (ADDR_W+1)'(addr);
    reqByteMode = byteM;
    extraCycle  = extra;
    clkDiv      = DIV_W'(div);
    k = 0; doneK = 0; lowK = 0; doneCnt = 0; finished = 0; got = '0;
    while (!finished && k < limit) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        reqValid = 1'b0;
        check(busy === 1'b1, "R7", "busy after accept", busy, 1);
      end
      if (poke && k == 4) begin
        reqValid = 1'b1;
        reqAddr  = (ADDR_W+1)'(addr ^ 5);
      end
      if (poke && k == 5) reqValid = 1'b0;
      if (done === 1'b1) begin
        doneCnt++;
        if (doneK == 0) begin
          doneK = k;
          got   = rdData;
          check(serCs === 1'b0, "R6", "chip select low at done", serCs, 0);
        end
      end
      if (doneK != 0 && busy === 1'b0) begin
        lowK     = k;
        finished = 1;
      end
    end
    check(doneK == lat + 1, "R5", "done latency", doneK, lat + 1);
    check(got == exp, extra ? "R4" : rq, "read data", got, exp);
    check(rxBits == expCmd, "R1", "command bits", rxBits, expCmd);
    check(rises == nBits, poke ? "R7" : "R4", "rising edges", rises, nBits);
    check(csViol == 0, "R6", "clock outside frame", csViol, 0);
    check(lowK - doneK == 2 * half, "R6", "closing gap", lowK - doneK, 2 * half);
    check(doneCnt == 1, "R8", "done pulse width", doneCnt, 1);
    repeat (3) @(negedge clk);
    check(rdData == got, "R8", "data held", rdData, got);
    check(busy === 1'b0 && done === 1'b0, "R7", "idle after transfer",
          {busy, done}, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int seedDummy;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqByteMode = 1'b0;
    extraCycle = 1'b0; clkDiv = '0;
    seedDummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check({busy, done, serCs, serClk, serOut} === 5'b0, "R9", "reset outputs",
          {busy, done, serCs, serClk, serOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    readOnce(0,   0, 0, 0, 0, 0);   // R2 lowest word address
    readOnce(63,  0, 0, 0, 3, 0);   // R2 highest word address, slow clock
    readOnce(127, 1, 0, 0, 1, 0);   // R3 highest byte address
    readOnce(21,  0, 1, 1, 0, 0);   // R4 extra pulse on lagging device
    readOnce(42,  0, 1, 0, 2, 0);   // R4 extra pulse on normal device
    readOnce(9,   0, 0, 1, 0, 0);   // R4 lagging device without pulse
    readOnce(77,  1, 1, 1, 1, 0);   // R4 byte mode with extra pulse
    readOnce(33,  0, 0, 0, 1, 1);   // R7 request while busy ignored

    for (int i = 0; i < 24; i++) begin
      bit bm, ex, lg;
      bm = 1'($urandom);
      ex = 1'($urandom);
      lg = $urandom_range(0, 3) == 0 ? ~ex : ex;
      readOnce(int'($urandom_range(0, bm ? 127 : 63)), bm, ex, lg,
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 4) == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule